// File: doc/BRIEF.md
# Sleep-Depth and Peripheral Power Controller

This block decides which power state a small microcontroller core is in and turns that state into clock and oscillator enables. It knows a running state, a shallow sleep in which only the CPU clock is gated, and a deep sleep in which the system clock and both fast oscillators are also stopped. It also has a settling state used on the way out of deep sleep. The CPU asks for a sleep depth with a one-cycle request. A set of wake sources brings the core back, and the legal set differs between the two depths.

An 8-bit power register holds active-low disable bits for the analog helper blocks: the op-amp, the supply monitors, the temperature sensor and two comparators. The register stays in force during deep sleep. The temperature sensor is always dropped in deep sleep. The brownout detector is kept there only when a separate always-on configuration input allows it. A deep-sleep exit first restarts the oscillators, waits a fixed settle count and then releases the clocks. On the first running cycle it gives a single-cycle recovery pulse.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `modeOut` is RUN. The mode encoding is 0 RUN, 1 HALT, 2 STOP, 3 WAKE. `regRdata` reads 0x80, so the op-amp is unpowered and every other helper is powered. All clock and oscillator enables are 1.
- R2: In RUN, `haltReq` moves the block to HALT on the next edge, unless a HALT wake source is also high. In HALT `cpuClkEn` is 0, while `sysClkEn`, `priOscEn` and `ipoEn` stay 1.
- R3: In HALT, `tmrIrq`, `intIrq` or `wdtTimeout` returns the block to RUN on the next edge with no recovery pulse. `tmrStopIrq`, `cmpStopIrq` and pin changes leave it in HALT.
- R4: In RUN, `stopReq` moves the block to STOP on the next edge and takes priority over `haltReq`. In STOP, `cpuClkEn`, `sysClkEn`, `priOscEn` and `ipoEn` are all 0.
- R5: In STOP, any of the following moves the block to WAKE on the next edge: `wdtTimeout`, `tmrStopIrq`, `cmpStopIrq`, or a level change on `pinIn[i]` while `pinRecEn[i]` is 1. `intIrq`, `tmrIrq` and changes on masked pins have no effect.
- R6: WAKE lasts exactly SETTLE (16) cycles and then returns to RUN. During WAKE `priOscEn` and `ipoEn` are 1, and `cpuClkEn` and `sysClkEn` are 0.
- R7: `recoverPulse` is 1 for exactly the first RUN cycle after WAKE, and 0 at all other times.
- R8: A sleep request that arrives in the same cycle as a wake source of the requested depth is dropped, and the block stays in RUN.
- R9: A write via `regWe` updates the power register. Bit 7 disables the op-amp, bit 4 the supply monitors, bit 3 the temperature sensor, bit 1 comparator 0 and bit 0 comparator 1, where 1 means unpowered. Bits 6, 5 and 2 read 0 and ignore writes.
- R10: In STOP and WAKE, the op-amp, comparator and low-voltage enables still follow the register, and `tempPwrEn` is 0. `vboPwrEn` is 1 only when bit 4 is 0 and `vboAlwaysOn` is 1. Outside these states, `vboPwrEn` and `tempPwrEn` follow their register bits.
- R11: In STOP and WAKE, `wdtOscEn` equals `wdtStopEn` and `secOscEn` equals `secOscStopEn`. `tmrClkEn` equals `tmrStopEn` AND `secOscStopEn`. In RUN and HALT all three are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Active-low reset (power-on, brownout or external pin) |
| haltReq | input | 1 | One-cycle request for shallow sleep |
| stopReq | input | 1 | One-cycle request for deep sleep |
| tmrIrq | input | 1 | Timer timeout event |
| intIrq | input | 1 | Enabled interrupt event |
| wdtTimeout | input | 1 | Watchdog timeout |
| tmrStopIrq | input | 1 | Interrupt from a timer enabled for deep sleep |
| cmpStopIrq | input | 1 | Interrupt from a comparator enabled for deep sleep |
| pinIn | input | NPINS | Synchronised port input levels |
| pinRecEn | input | NPINS | Per-pin deep-sleep recovery enable |
| vboAlwaysOn | input | 1 | Brownout detector allowed in deep sleep |
| wdtStopEn | input | 1 | Watchdog RC oscillator kept in deep sleep |
| secOscStopEn | input | 1 | 32 kHz secondary oscillator kept in deep sleep |
| tmrStopEn | input | 1 | Timers allowed to run in deep sleep |
| regWe | input | 1 | Power register write strobe |
| regWdata | input | 8 | Power register write data |
| regRdata | output | 8 | Power register read data |
| modeOut | output | 2 | Current mode (0 RUN, 1 HALT, 2 STOP, 3 WAKE) |
| cpuClkEn | output | 1 | CPU clock enable |
| sysClkEn | output | 1 | System clock enable |
| priOscEn | output | 1 | Primary crystal oscillator enable |
| ipoEn | output | 1 | Internal precision oscillator enable |
| wdtOscEn | output | 1 | Watchdog RC oscillator enable |
| secOscEn | output | 1 | Secondary oscillator enable |
| tmrClkEn | output | 1 | Timer clock enable |
| opampPwrEn | output | 1 | Op-amp power |
| lvdPwrEn | output | 1 | Low-voltage detector power |
| vboPwrEn | output | 1 | Brownout detector power |
| tempPwrEn | output | 1 | Temperature sensor power |
| cmp0PwrEn | output | 1 | Comparator 0 power |
| cmp1PwrEn | output | 1 | Comparator 1 power |
| recoverPulse | output | 1 | One-cycle pulse on deep-sleep exit |

## Verification
Mode changes and register writes appear one edge after the cycle that carries the stimulus. The enables depend only on the mode, the register and the configuration inputs, so they follow in that same cycle. A deep-sleep exit shows WAKE one edge after the wake source. RUN and the recovery pulse appear 17 edges after it, and the pulse is gone one edge later. The bench drives inputs on the falling edge and samples one falling edge after each rising edge it waits for. It counts the edges of the settle window explicitly, so every check lands in the exact cycle given above.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_WAKE = 2'd3
  } pwrMode_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic recSet;
  } dpStrobe_t;

  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] REG_RESET = 8'h80;
  localparam logic [REG_W-1:0] REG_WMASK = 8'h9B;
  localparam int BIT_OPAMP = 7;
  localparam int BIT_SUPMON = 4;
  localparam int BIT_TEMP = 3;
  localparam int BIT_CMP0 = 1;
  localparam int BIT_CMP1 = 0;
endpackage

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_mode_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int SETTLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] pinRecEn,
  output logic [REG_W-1:0] pwrReg,
  output logic             pinWake,
  output logic             cntDone,
  output logic             recoverPulse
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);

  logic [NPINS-1:0] pinPrev;
  logic [CW-1:0]    settleCnt;

  // power register: reserved positions never take a 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrReg <= REG_RESET;
    else if (regWe) pwrReg <= regWdata & REG_WMASK;
  end

  // recovery pin change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else pinPrev <= pinIn;
  end

  logic [NPINS-1:0] pinHit;
  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      assign pinHit[gi] = pinRecEn[gi] & (pinIn[gi] ^ pinPrev[gi]);
    end
  endgenerate
  assign pinWake = |pinHit;

  // oscillator settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) settleCnt <= '0;
    else if (strobe.cntClr) settleCnt <= '0;
    else if (strobe.cntInc) settleCnt <= settleCnt + 1'b1;
  end
  assign cntDone = (settleCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recoverPulse <= 1'b0;
    else recoverPulse <= strobe.recSet;
  end
endmodule

// File: rtl/pwr_control.sv
module pwr_control
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltReq,
  input  logic             stopReq,
  input  logic             tmrIrq,
  input  logic             intIrq,
  input  logic             wdtTimeout,
  input  logic             tmrStopIrq,
  input  logic             cmpStopIrq,
  input  logic             pinWake,
  input  logic             cntDone,
  input  logic [REG_W-1:0] pwrReg,
  input  logic             vboAlwaysOn,
  input  logic             wdtStopEn,
  input  logic             secOscStopEn,
  input  logic             tmrStopEn,
  output pwrMode_t         mode,
  output dpStrobe_t        strobe,
  output logic             cpuClkEn,
  output logic             sysClkEn,
  output logic             priOscEn,
  output logic             ipoEn,
  output logic             wdtOscEn,
  output logic             secOscEn,
  output logic             tmrClkEn,
  output logic             opampPwrEn,
  output logic             lvdPwrEn,
  output logic             vboPwrEn,
  output logic             tempPwrEn,
  output logic             cmp0PwrEn,
  output logic             cmp1PwrEn
);
  pwrMode_t modeNext;
  logic haltWake, stopWake, deep;

  assign haltWake = tmrIrq | intIrq | wdtTimeout;
  assign stopWake = wdtTimeout | pinWake | tmrStopIrq | cmpStopIrq;

  always_comb begin
    modeNext = mode;
    strobe   = '0;
    unique case (mode)
      MODE_RUN: begin
        if (stopReq) begin
          if (!stopWake) modeNext = MODE_STOP;
        end else if (haltReq && !haltWake) begin
          modeNext = MODE_HALT;
        end
      end
      MODE_HALT: if (haltWake) modeNext = MODE_RUN;
      MODE_STOP: begin
        if (stopWake) begin
          modeNext      = MODE_WAKE;
          strobe.cntClr = 1'b1;
        end
      end
      MODE_WAKE: begin
        strobe.cntInc = 1'b1;
        if (cntDone) begin
          modeNext      = MODE_RUN;
          strobe.recSet = 1'b1;
        end
      end
      default: modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_RUN;
    else mode <= modeNext;
  end

  // clock and oscillator gating per mode
  assign deep     = (mode == MODE_STOP) || (mode == MODE_WAKE);
  assign cpuClkEn = (mode == MODE_RUN);
  assign sysClkEn = !deep;
  assign priOscEn = (mode != MODE_STOP);
  assign ipoEn    = (mode != MODE_STOP);
  assign wdtOscEn = deep ? wdtStopEn : 1'b1;
  assign secOscEn = deep ? secOscStopEn : 1'b1;
  assign tmrClkEn = deep ? (tmrStopEn & secOscStopEn) : 1'b1;

  // analog helper power, active-low register bits
  assign opampPwrEn = !pwrReg[BIT_OPAMP];
  assign lvdPwrEn   = !pwrReg[BIT_SUPMON];
  assign vboPwrEn   = !pwrReg[BIT_SUPMON] && (!deep || vboAlwaysOn);
  assign tempPwrEn  = !pwrReg[BIT_TEMP] && !deep;
  assign cmp0PwrEn  = !pwrReg[BIT_CMP0];
  assign cmp1PwrEn  = !pwrReg[BIT_CMP1];
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int SETTLE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltReq,
  input  logic             stopReq,
  input  logic             tmrIrq,
  input  logic             intIrq,
  input  logic             wdtTimeout,
  input  logic             tmrStopIrq,
  input  logic             cmpStopIrq,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] pinRecEn,
  input  logic             vboAlwaysOn,
  input  logic             wdtStopEn,
  input  logic             secOscStopEn,
  input  logic             tmrStopEn,
  input  logic             regWe,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic [1:0]       modeOut,
  output logic             cpuClkEn,
  output logic             sysClkEn,
  output logic             priOscEn,
  output logic             ipoEn,
  output logic             wdtOscEn,
  output logic             secOscEn,
  output logic             tmrClkEn,
  output logic             opampPwrEn,
  output logic             lvdPwrEn,
  output logic             vboPwrEn,
  output logic             tempPwrEn,
  output logic             cmp0PwrEn,
  output logic             cmp1PwrEn,
  output logic             recoverPulse
);
  dpStrobe_t strobe;
  pwrMode_t  mode;
  logic [REG_W-1:0] pwrReg;
  logic pinWake, cntDone;

  pwr_datapath #(.NPINS(NPINS), .SETTLE(SETTLE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWe(regWe), .regWdata(regWdata),
    .pinIn(pinIn), .pinRecEn(pinRecEn), .pwrReg(pwrReg), .pinWake(pinWake),
    .cntDone(cntDone), .recoverPulse(recoverPulse)
  );

  pwr_control u_ctl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .stopReq(stopReq), .tmrIrq(tmrIrq),
    .intIrq(intIrq), .wdtTimeout(wdtTimeout), .tmrStopIrq(tmrStopIrq),
    .cmpStopIrq(cmpStopIrq), .pinWake(pinWake), .cntDone(cntDone), .pwrReg(pwrReg),
    .vboAlwaysOn(vboAlwaysOn), .wdtStopEn(wdtStopEn), .secOscStopEn(secOscStopEn),
    .tmrStopEn(tmrStopEn), .mode(mode), .strobe(strobe), .cpuClkEn(cpuClkEn),
    .sysClkEn(sysClkEn), .priOscEn(priOscEn), .ipoEn(ipoEn), .wdtOscEn(wdtOscEn),
    .secOscEn(secOscEn), .tmrClkEn(tmrClkEn), .opampPwrEn(opampPwrEn),
    .lvdPwrEn(lvdPwrEn), .vboPwrEn(vboPwrEn), .tempPwrEn(tempPwrEn),
    .cmp0PwrEn(cmp0PwrEn), .cmp1PwrEn(cmp1PwrEn)
  );

  assign regRdata = pwrReg;
  assign modeOut  = mode;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int SETTLE = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       haltReq,
  input logic       stopReq,
  input logic       intIrq,
  input logic       wdtTimeout,
  input logic [1:0] modeOut,
  input logic       cpuClkEn,
  input logic       sysClkEn,
  input logic       priOscEn,
  input logic       ipoEn,
  input logic       tempPwrEn,
  input logic [7:0] regRdata,
  input logic       recoverPulse
);
  int wakeLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeLen <= 0;
    else if (modeOut == 2'd2) wakeLen <= 0;
    else if (modeOut == 2'd3) wakeLen <= wakeLen + 1;
  end

  p_halt_clocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == 2'd1 |-> (!cpuClkEn && sysClkEn && priOscEn && ipoEn));
  p_halt_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd1 && intIrq) |=> (modeOut == 2'd0 && !recoverPulse));
  p_stop_clocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == 2'd2 |-> (!cpuClkEn && !sysClkEn && !priOscEn && !ipoEn && !tempPwrEn));
  p_wdt_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd2 && wdtTimeout) |=> modeOut == 2'd3);
  p_settle_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0 && $past(modeOut) == 2'd3) |-> wakeLen == SETTLE);
  p_pulse_place_r7: assert property (@(posedge clk) disable iff (!rstN)
    recoverPulse |-> (modeOut == 2'd0 && $past(modeOut) == 2'd3));
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    recoverPulse |=> !recoverPulse);
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0 && stopReq && wdtTimeout) |=> modeOut == 2'd0);
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata & 8'h64) == 8'h00);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.SETTLE(SETTLE)) u_chk (
  .clk(clk), .rstN(rstN), .haltReq(haltReq), .stopReq(stopReq), .intIrq(intIrq),
  .wdtTimeout(wdtTimeout), .modeOut(modeOut), .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn),
  .priOscEn(priOscEn), .ipoEn(ipoEn), .tempPwrEn(tempPwrEn), .regRdata(regRdata),
  .recoverPulse(recoverPulse)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int NPINS = 8;
  localparam int SETTLE = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic haltReq = 0, stopReq = 0, tmrIrq = 0, intIrq = 0, wdtTimeout = 0;
  logic tmrStopIrq = 0, cmpStopIrq = 0;
  logic [NPINS-1:0] pinIn = '0, pinRecEn = 8'h01;
  logic vboAlwaysOn = 0, wdtStopEn = 0, secOscStopEn = 0, tmrStopEn = 0;
  logic regWe = 0;
  logic [7:0] regWdata = '0, regRdata;
  logic [1:0] modeOut;
  logic cpuClkEn, sysClkEn, priOscEn, ipoEn, wdtOscEn, secOscEn, tmrClkEn;
  logic opampPwrEn, lvdPwrEn, vboPwrEn, tempPwrEn, cmp0PwrEn, cmp1PwrEn, recoverPulse;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.NPINS(NPINS), .SETTLE(SETTLE)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // row: [11]halt [10]stop [9]tmr [8]int [7]wdt [6]tmrStop [5]cmpStop [4:3]pinToggle [2]unused [1:0]expected mode
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    12'b1000_0000_0001,  // R2 halt entry
    12'b0000_0000_0001,  // R2 holds
    12'b0000_0100_0001,  // R3 stop-only source ignored in HALT
    12'b0001_0000_0000,  // R3 interrupt exits
    12'b1001_0000_0000,  // R8 cancel halt
    12'b1000_0000_0001,  // R2
    12'b0000_1000_0000,  // R3 watchdog exits
    12'b1000_0000_0001,  // R2
    12'b0010_0000_0000,  // R3 timer exits
    12'b1100_0000_0010,  // R4 stop wins over halt
    12'b0001_0000_0010,  // R5 interrupt ignored in STOP
    12'b0010_0000_0010,  // R5 timer timeout ignored in STOP
    12'b0000_0001_0010,  // R5 masked pin change ignored
    12'b0000_0010_0011   // R5 comparator wakes
  };

  task automatic clearIn();
    haltReq = 0; stopReq = 0; tmrIrq = 0; intIrq = 0; wdtTimeout = 0;
    tmrStopIrq = 0; cmpStopIrq = 0; regWe = 0;
  endtask

  task automatic stepOne();
    @(negedge clk);
    clearIn();
  endtask

  task automatic writeReg(input logic [7:0] d);
    regWe = 1; regWdata = d;
    stepOne();
  endtask

  task automatic waitSettle(input string tag);
    // WAKE was entered at the previous edge; 15 more edges stay in WAKE
    for (int k = 0; k < SETTLE - 1; k++) stepOne();
    chk({tag, " R6 still WAKE"}, modeOut, 3);
    chk({tag, " R7 no early pulse"}, recoverPulse, 0);
    stepOne();
    chk({tag, " R6 back to RUN"}, modeOut, 0);
    chk({tag, " R7 pulse"}, recoverPulse, 1);
    stepOne();
    chk({tag, " R7 pulse ends"}, recoverPulse, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", modeOut, 0);
    chk("R1 reg", regRdata, 8'h80);
    chk("R1 clocks", {cpuClkEn, sysClkEn, priOscEn, ipoEn, wdtOscEn, secOscEn, tmrClkEn}, 7'h7F);
    chk("R1 helpers", {opampPwrEn, lvdPwrEn, vboPwrEn, tempPwrEn, cmp0PwrEn, cmp1PwrEn}, 6'b011111);

    for (int v = 0; v < NV; v++) begin
      haltReq = VEC[v][11]; stopReq = VEC[v][10]; tmrIrq = VEC[v][9];
      intIrq = VEC[v][8]; wdtTimeout = VEC[v][7]; tmrStopIrq = VEC[v][6];
      cmpStopIrq = VEC[v][5]; pinIn = pinIn ^ {6'b0, VEC[v][4:3]};
      stepOne();
      chk($sformatf("R2-5 vector %0d mode", v), modeOut, VEC[v][1:0]);
      if (VEC[v][1:0] == 2'd1)
        chk("R2 halt gating", {cpuClkEn, sysClkEn, priOscEn, ipoEn}, 4'b0111);
      if (VEC[v][1:0] == 2'd0)
        chk("R3 no pulse on halt exit", recoverPulse, 0);
      if (VEC[v][1:0] == 2'd2)
        chk("R4 stop gating", {cpuClkEn, sysClkEn, priOscEn, ipoEn}, 4'b0000);
      if (VEC[v][1:0] == 2'd3)
        chk("R6 wake gating", {cpuClkEn, sysClkEn, priOscEn, ipoEn}, 4'b0011);
    end
    waitSettle("cmp");

    // R3 pin change does not exit HALT
    haltReq = 1; stepOne();
    pinIn[0] = ~pinIn[0]; stepOne();
    chk("R3 pin ignored in HALT", modeOut, 1);
    intIrq = 1; stepOne();

    // R5 enabled pin wakes STOP
    stopReq = 1; stepOne();
    pinIn[0] = ~pinIn[0]; stepOne();
    chk("R5 pin wake", modeOut, 3);
    waitSettle("pin");

    // R8 cancel STOP entry
    stopReq = 1; wdtTimeout = 1; stepOne();
    chk("R8 stop cancelled", modeOut, 0);

    // R9 register write and reserved bits
    writeReg(8'hFF);
    chk("R9 reserved masked", regRdata, 8'h9B);
    chk("R9 all helpers off", {opampPwrEn, lvdPwrEn, vboPwrEn, tempPwrEn, cmp0PwrEn, cmp1PwrEn}, 6'b0);
    writeReg(8'h64);
    chk("R9 reserved only", regRdata, 8'h00);
    chk("R9 all helpers on", {opampPwrEn, lvdPwrEn, vboPwrEn, tempPwrEn, cmp0PwrEn, cmp1PwrEn}, 6'b111111);
    writeReg(8'h02);
    chk("R9 cmp0 off", {cmp0PwrEn, cmp1PwrEn}, 2'b01);
    writeReg(8'h00);

    // R10 / R11 deep sleep helpers and keep-alive enables
    wdtStopEn = 1; secOscStopEn = 0; tmrStopEn = 1;
    stopReq = 1; stepOne();
    chk("R10 stop helpers", {opampPwrEn, lvdPwrEn, vboPwrEn, tempPwrEn, cmp0PwrEn, cmp1PwrEn}, 6'b110011);
    chk("R11 keep-alive", {wdtOscEn, secOscEn, tmrClkEn}, 3'b100);
    vboAlwaysOn = 1; #1;
    chk("R10 vbo always-on", vboPwrEn, 1);
    secOscStopEn = 1; wdtStopEn = 0; #1;
    chk("R11 timer with secondary osc", {wdtOscEn, secOscEn, tmrClkEn}, 3'b011);
    tmrStopIrq = 1; stepOne();
    chk("R5 timer stop irq wake", modeOut, 3);
    chk("R10 temp off in WAKE", tempPwrEn, 0);
    waitSettle("tmr");
    chk("R11 run enables", {wdtOscEn, secOscEn, tmrClkEn}, 3'b111);
    chk("R10 temp back in RUN", tempPwrEn, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule